// File: doc/BRIEF.md
# Synchronous Master Serial Clock Engine

This block is the synchronous master datapath of a UART. When the master-select input is high it produces the serial clock itself from the 1x baud tick, sends transmit frames on `sdo`, and samples `sdi` on the same clock. All of this runs in the UART clock domain. Each baud tick toggles an internal clock phase, so one serial bit takes two ticks. The low half ends with a rising `sclk` edge, where the incoming bit is sampled. The high half ends with a falling edge, where the next outgoing bit is placed on the line.

A frame is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). A byte is offered through a valid/ready handshake.

With the continuous-clock input low, `sclk` pulses only during data bits and rests low at all other times. With it high, `sclk` runs through every bit position. Frames then follow one another even when no byte is queued. An idle frame carries all ones, and an attached slave can use it to send a byte of its own, marked by a start bit. Received bytes appear on `rx_data` with a one-cycle `rx_valid` strobe.

Top module: `smclk_engine`

## Requirements
- R1: A clock edge with `rst` high ends any frame. In the following cycle `sclk` is low, `sdo` is high and `rx_valid` is low (and `tx_ready` is low while `master_en` is low).
- R2: While `master_en` is low, in that same cycle `sclk` is low, `sdo` is high, `tx_ready` is low and `rx_valid` is low, and `tx_valid` is ignored. A frame in progress when `master_en` falls is dropped and is not resumed when `master_en` returns.
- R3: `tx_ready` is high exactly when `master_en` is high and no frame is in progress. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the frame has ended.
- R4: After an accept, `sdo` carries the start bit (0) from the next cycle. It then carries the eight data bits with bit 0 first and the stop bit (1), and then rests high. Each bit is on `sdo` at the rising `sclk` edge of its own bit period.
- R5: `sclk` changes level only in the cycle after a cycle with `baud_tick` high, and each tick inside a frame toggles the phase. `sdo` never changes while `sclk` is high.
- R6: With `cont_clk_en` low, `sclk` stays low during the start bit, the stop bit and while idle. A frame therefore shows exactly 8 rising `sclk` edges.
- R7: With `cont_clk_en` high, `sclk` runs through all 10 bit positions, giving 10 rising edges per frame. Frames keep running with no byte queued. In such an idle frame `sdo` is 1 in every data position.
- R8: `sdi` is sampled with no synchronizer at the edge that raises `sclk` in each data bit, and is assembled with the first bit as bit 0. After every frame that carried a transmit byte, `rx_valid` is high for exactly one cycle, the cycle in which `sclk` is high for the last data bit, and `rx_data` then holds the byte.
- R9: In an idle frame with the continuous clock running, a byte is reported only if `sdi` was 0 at the start-bit rising edge. Otherwise `rx_valid` stays low for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART domain clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Selects synchronous master operation |
| cont_clk_en | input | 1 | Keeps `sclk` running through start, stop and idle |
| baud_tick | input | 1 | One-cycle 1x baud pulse; each pulse is one half bit |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Engine can accept a byte |
| sdi | input | 1 | Serial data from the slave |
| sclk | output | 1 | Generated serial clock, idle low |
| sdo | output | 1 | Serial data to the slave, idle high |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The outputs are driven from registers that change on the rising clock edge, so the bench samples them on the falling edge in between.

Timing of each result:
- An accepted byte shows its start bit on `sdo`, and `tx_ready` drops, one edge after the accepting edge.
- An `sclk` transition appears one edge after the cycle in which `baud_tick` was high. The bench records the tick value the design saw at that edge and checks each observed transition against it.
- `rx_valid` rises at the same edge that raises `sclk` for the last data bit. The bench therefore checks it at the falling edge where it first sees the eighth data rise, and checks that the pulse occurs only once in the frame.
- Dropping `master_en` silences the outputs within the same cycle, so that check is made one time step after the input changes.

// File: rtl/smclk_pkg.sv
package smclk_pkg;

    localparam int unsigned DATA_BITS_DEF = 8;

    // Position of the engine inside a serial frame.
    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_START,
        SLOT_DATA,
        SLOT_STOP
    } slot_e;

    // Frame sequencer state.
    typedef struct packed {
        logic running;     // a frame is in progress
        logic high_half;   // serial clock phase: 1 = high half of the bit
        logic carries_tx;  // frame was started with a transmit byte
    } seq_flags_t;

    // Single-cycle events derived from the sequencer.
    typedef struct packed {
        logic frame_go;    // a frame starts at this edge
        logic rise;        // low half ends: sample point
        logic fall;        // high half ends: launch point
    } seq_evt_t;

    function automatic int unsigned idx_width(input int unsigned data_bits);
        return $clog2(data_bits + 2);
    endfunction

    function automatic slot_e slot_of(input logic running,
                                      input int unsigned idx,
                                      input int unsigned data_bits);
        if (!running)
            return SLOT_IDLE;
        if (idx == 0)
            return SLOT_START;
        if (idx > data_bits)
            return SLOT_STOP;
        return SLOT_DATA;
    endfunction

endpackage

// File: rtl/smclk_seq.sv
module smclk_seq
    import smclk_pkg::*;
#(
    parameter  int unsigned DATA_W = DATA_BITS_DEF,
    localparam int unsigned IDX_W  = idx_width(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_en,
    input  logic             cont_en,
    input  logic             baud_tick,
    input  logic             tx_valid,
    output seq_flags_t       flags,
    output logic [IDX_W-1:0] idx,
    output slot_e            slot,
    output seq_evt_t         evt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W + 1);

    seq_flags_t       flags_q;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        evt.frame_go = master_en && !flags_q.running && (tx_valid || cont_en);
        evt.rise     = master_en && flags_q.running && baud_tick && !flags_q.high_half;
        evt.fall     = master_en && flags_q.running && baud_tick &&  flags_q.high_half;
    end

    always_ff @(posedge clk) begin
        if (rst || !master_en) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else if (evt.frame_go) begin
            flags_q <= '{running: 1'b1, high_half: 1'b0, carries_tx: tx_valid};
            idx_q   <= '0;
        end else if (evt.rise) begin
            flags_q.high_half <= 1'b1;
        end else if (evt.fall) begin
            flags_q.high_half <= 1'b0;
            if (idx_q == LAST_IDX) begin
                flags_q.running    <= 1'b0;
                flags_q.carries_tx <= 1'b0;
                idx_q              <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign flags = flags_q;
    assign idx   = idx_q;
    assign slot  = slot_of(flags_q.running, 32'(idx_q), DATA_W);

endmodule

// File: rtl/smclk_tx.sv
module smclk_tx
    import smclk_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              frame_go,
    input  logic              fall,
    input  slot_e             slot,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo
);

    logic [DATA_W-1:0] shreg_q;

    // Idle frames load all ones so the data positions stay high.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '1;
        end else if (frame_go) begin
            shreg_q <= tx_valid ? tx_data : '1;
        end else if (fall && slot == SLOT_DATA) begin
            shreg_q <= {1'b1, shreg_q[DATA_W-1:1]};
        end
    end

    always_comb begin
        if (!master_en) begin
            sdo = 1'b1;
        end else begin
            unique case (slot)
                SLOT_START: sdo = 1'b0;
                SLOT_DATA:  sdo = shreg_q[0];
                default:    sdo = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/smclk_rx.sv
module smclk_rx
    import smclk_pkg::*;
#(
    parameter  int unsigned DATA_W = DATA_BITS_DEF,
    localparam int unsigned IDX_W  = idx_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              frame_go,
    input  logic              rise,
    input  slot_e             slot,
    input  logic [IDX_W-1:0]  idx,
    input  logic              carries_tx,
    input  logic              sdi,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] data_q;
    logic              start_low_q;
    logic              valid_q;
    logic [DATA_W-1:0] next_sh;

    // First bit received ends up in bit 0.
    assign next_sh = {sdi, sh_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q        <= '0;
            data_q      <= '0;
            start_low_q <= 1'b0;
            valid_q     <= 1'b0;
        end else if (!master_en) begin
            start_low_q <= 1'b0;
            valid_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (frame_go) begin
                start_low_q <= 1'b0;
            end else if (rise) begin
                if (slot == SLOT_START)
                    start_low_q <= !sdi;
                if (slot == SLOT_DATA) begin
                    sh_q <= next_sh;
                    if (idx == LAST_DATA) begin
                        data_q  <= next_sh;
                        valid_q <= carries_tx || start_low_q;
                    end
                end
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q && master_en;

endmodule

// File: rtl/smclk_engine.sv
module smclk_engine
    import smclk_pkg::*;
#(
    parameter  int unsigned DATA_W = DATA_BITS_DEF,
    localparam int unsigned IDX_W  = idx_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              cont_clk_en,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    seq_flags_t       flags;
    seq_evt_t         evt;
    slot_e            slot;
    logic [IDX_W-1:0] idx;

    smclk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .master_en (master_en),
        .cont_en   (cont_clk_en),
        .baud_tick (baud_tick),
        .tx_valid  (tx_valid),
        .flags     (flags),
        .idx       (idx),
        .slot      (slot),
        .evt       (evt)
    );

    smclk_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .master_en (master_en),
        .frame_go  (evt.frame_go),
        .fall      (evt.fall),
        .slot      (slot),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .sdo       (sdo)
    );

    smclk_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .master_en  (master_en),
        .frame_go   (evt.frame_go),
        .rise       (evt.rise),
        .slot       (slot),
        .idx        (idx),
        .carries_tx (flags.carries_tx),
        .sdi        (sdi),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid)
    );

    // Clock is gated to data bits unless the continuous mode is on.
    assign sclk     = master_en && flags.running && flags.high_half
                      && (slot == SLOT_DATA || cont_clk_en);
    assign tx_ready = master_en && !flags.running;

endmodule

// File: rtl/smclk_engine_chk.sv
module smclk_engine_chk (
    input logic clk,
    input logic rst,
    input logic master_en,
    input logic cont_clk_en,
    input logic baud_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic sclk,
    input logic sdo,
    input logic rx_valid
);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> (!sclk && sdo && !tx_ready && !rx_valid));

    p_accept_drops_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_start_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (!sdo || !master_en));

    p_rise_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && $stable(cont_clk_en)) |-> $past(baud_tick));

    p_sdo_steady_high_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdo));

    p_idle_clock_low_r6: assert property (@(posedge clk) disable iff (rst)
        (!cont_clk_en && tx_ready) |-> !sclk);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_valid_with_rise_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> sclk);

endmodule

bind smclk_engine smclk_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .master_en   (master_en),
    .cont_clk_en (cont_clk_en),
    .baud_tick   (baud_tick),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .sclk        (sclk),
    .sdo         (sdo),
    .rx_valid    (rx_valid)
);

// File: tb/smclk_engine_bench.sv
`timescale 1ns/1ps
module smclk_engine_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       master_en;
    logic       cont_clk_en;
    logic       baud_tick;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       sdi;
    logic       sclk;
    logic       sdo;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       tick_seen = 1'b0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    smclk_engine u_smclk_engine (
        .clk         (clk),
        .rst         (rst),
        .master_en   (master_en),
        .cont_clk_en (cont_clk_en),
        .baud_tick   (baud_tick),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .sdi         (sdi),
        .sclk        (sclk),
        .sdo         (sdo),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid)
    );

    // Tick value the design saw at the most recent edge.
    always @(posedge clk) tick_seen <= baud_tick;

    // One baud tick every four clocks.
    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic drain();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tx_ready && guard < 400);
    endtask

    // One frame: optional master byte, optional slave byte on sdi.
    task automatic frame_exchange(input logic send_tx, input logic [7:0] txb,
                                  input logic slave_send, input logic [7:0] sb);
        logic       q[10];
        logic       cont;
        logic       ps, pd, done, valid_at_last;
        logic [7:0] got;
        int ptr, rises, drise, nvalid, guard, edge_no_tick, sdo_while_high;
        logic       exp_valid;
        cont = cont_clk_en;
        for (int i = 0; i < 10; i++) q[i] = 1'b1;
        if (cont) begin
            q[0] = !slave_send;
            for (int i = 0; i < 8; i++) q[i+1] = slave_send ? sb[i] : 1'b1;
        end else begin
            for (int i = 0; i < 8; i++) q[i] = slave_send ? sb[i] : 1'b1;
        end
        if (send_tx) begin
            tx_data  = txb;
            tx_valid = 1'b1;
        end
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tx_ready && guard < 400);
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R3 tx_ready low once frame starts", tx_ready, 0);
        chk("R4 start bit on sdo after accept", sdo, 0);
        sdi = q[0];
        ptr = 0; rises = 0; nvalid = 0; guard = 0;
        edge_no_tick = 0; sdo_while_high = 0; valid_at_last = 1'b0;
        got = 8'h00; ps = sclk; pd = sdo; done = 1'b0;
        while (!done && guard < 400) begin
            @(negedge clk);
            guard++;
            if (rx_valid) nvalid++;
            if (sclk && !ps) begin
                rises++;
                if (!tick_seen) edge_no_tick++;
                drise = cont ? rises - 1 : rises;
                if (drise >= 1 && drise <= 8) got[drise-1] = sdo;
                if (drise == 8) valid_at_last = rx_valid;
            end
            if (!sclk && ps) begin
                if (!tick_seen) edge_no_tick++;
                if (ptr < 9) ptr++;
                sdi = q[ptr];
            end
            if (sdo !== pd && sclk) sdo_while_high++;
            ps = sclk;
            pd = sdo;
            if (tx_ready) done = 1'b1;
        end
        exp_valid = send_tx || slave_send;
        chk("R3 tx_ready returns after frame", done, 1);
        if (cont) chk("R7 rising sclk edges per frame", rises, 10);
        else      chk("R6 rising sclk edges per frame", rises, 8);
        chk("R4 data bits on sdo LSB first", got, send_tx ? txb : 8'hFF);
        chk("R5 sclk edges follow a tick", edge_no_tick, 0);
        chk("R5 sdo steady while sclk high", sdo_while_high, 0);
        if (send_tx) chk("R8 rx_valid with last data rise", valid_at_last, 1);
        else         chk("R9 rx_valid with last data rise", valid_at_last, exp_valid);
        if (send_tx) chk("R8 rx_valid pulse count", nvalid, 1);
        else         chk("R9 rx_valid pulse count", nvalid, exp_valid ? 1 : 0);
        if (exp_valid) chk("R8 rx_data value", rx_data, slave_send ? sb : 8'hFF);
        if (!cont) chk("R4 sdo idle high after stop", sdo, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        master_en = 1'b0; cont_clk_en = 1'b0;
        tx_valid = 1'b0; tx_data = 8'h00; sdi = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 sclk low in reset", sclk, 0);
        chk("R1 sdo high in reset", sdo, 1);
        chk("R1 rx_valid low in reset", rx_valid, 0);
        chk("R1 tx_ready low in reset", tx_ready, 0);
        rst = 1'b0;
    endtask

    task automatic t_disabled();
        int sclk_hi = 0, sdo_lo = 0, ready_hi = 0;
        tx_data = 8'h3C; tx_valid = 1'b1;
        repeat (50) begin
            @(negedge clk);
            if (sclk) sclk_hi++;
            if (!sdo) sdo_lo++;
            if (tx_ready) ready_hi++;
        end
        chk("R2 sclk held low while disabled", sclk_hi, 0);
        chk("R2 sdo held high while disabled", sdo_lo, 0);
        chk("R2 tx_ready low while disabled", ready_hi, 0);
        tx_valid = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        #1;
        chk("R2 tx_valid while disabled started nothing", tx_ready, 1);
    endtask

    task automatic t_idle_gated();
        int sclk_hi = 0, sdo_lo = 0;
        repeat (60) begin
            @(negedge clk);
            if (sclk) sclk_hi++;
            if (!sdo) sdo_lo++;
        end
        chk("R6 sclk low while idle", sclk_hi, 0);
        chk("R6 sdo high while idle", sdo_lo, 0);
    endtask

    task automatic t_noncont_frames();
        frame_exchange(1'b1, 8'hA5, 1'b1, 8'h3C);
        frame_exchange(1'b1, 8'h01, 1'b1, 8'h80);
        frame_exchange(1'b1, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic t_cont_idle();
        int rises = 0;
        logic ps;
        cont_clk_en = 1'b1;
        ps = sclk;
        repeat (60) begin
            @(negedge clk);
            if (sclk && !ps) rises++;
            ps = sclk;
        end
        chk("R7 clock runs with nothing queued", rises > 4, 1);
        frame_exchange(1'b0, 8'h00, 1'b0, 8'h00);
        frame_exchange(1'b0, 8'h00, 1'b1, 8'hC3);
    endtask

    task automatic t_cont_loaded();
        frame_exchange(1'b1, 8'h96, 1'b0, 8'h00);
        frame_exchange(1'b1, 8'h5A, 1'b1, 8'hE7);
    endtask

    task automatic t_abort();
        int guard = 0, sclk_hi = 0;
        cont_clk_en = 1'b0;
        drain();
        tx_data = 8'hAA; tx_valid = 1'b1;
        do begin
            @(negedge clk);
            guard++;
            if (!tx_ready) tx_valid = 1'b0;
        end while (!sclk && guard < 400);
        tx_valid = 1'b0;
        master_en = 1'b0;
        #1;
        chk("R2 sclk drops when master_en falls", sclk, 0);
        chk("R2 sdo high when master_en falls", sdo, 1);
        chk("R2 tx_ready low when master_en falls", tx_ready, 0);
        @(negedge clk);
        master_en = 1'b1;
        #1;
        chk("R2 dropped frame not resumed", tx_ready, 1);
        repeat (40) begin
            @(negedge clk);
            if (sclk) sclk_hi++;
        end
        chk("R2 no clock after dropped frame", sclk_hi, 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_idle_gated();
        t_noncont_frames();
        t_cont_idle();
        t_cont_loaded();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule